// File: doc/BRIEF.md
# Mailbox Receive Overrun Status Tracker

This block keeps two status flags for each of 32 message mailboxes in a CAN-style controller. The first is a receive-pending flag, which shows that a frame was stored and software has not yet taken it. The second is an unread-overwrite flag, which shows that a later frame replaced a stored frame before software acknowledged it. The receive path reports each stored frame with a one-cycle strobe and a mailbox index. A per-mailbox direction vector marks which mailboxes transmit. Strobes aimed at transmit mailboxes leave both flags untouched.

Software reaches both flag sets through a small word-addressed register port. Each 32-bit set is split into two 16-bit halves. Software can only clear bits, by writing ones to them. Read data is registered and appears on the cycle after the read request.

Top module: `mbox_rx_status`

## Requirements
- R1: The register map is as follows. Address 0 holds the pending flags of mailboxes 15..0 and address 1 holds those of mailboxes 31..16. Address 2 holds the overwrite flags of mailboxes 15..0 and address 3 holds those of mailboxes 31..16. In each half, bit n belongs to the mailbox at position n of that half, so bit n of address 3 is mailbox 16+n.
- R2: After reset, all pending flags and all overwrite flags are 0, and the read data output is 0.
- R3: A register write clears every flag whose write-data bit is 1 and leaves every flag whose bit is 0 unchanged. A write never sets a flag.
- R4: A store strobe for a receive mailbox whose pending flag is already 1 sets that mailbox's overwrite flag.
- R5: A store strobe for a mailbox whose direction bit is 1 (transmit) changes neither the pending flag nor the overwrite flag of any mailbox.
- R6: A store strobe for a receive mailbox whose pending flag is 0 sets the pending flag only. The overwrite flag is left as it was.
- R7: When a store strobe and a clearing write hit the same flag in the same cycle, the store wins and the flag ends at 1. This holds for both the pending and the overwrite flags.
- R8: The read data output carries the addressed half on the cycle after a read request. It shows the flag values from before any update made in the request cycle. It is 0 on any cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| boxDir | input | 32 | Per-mailbox direction: 1 = transmit, 0 = receive |
| storeValid | input | 1 | One-cycle strobe: a frame was stored into a mailbox |
| storeIdx | input | 5 | Mailbox index of the stored frame |
| regAddr | input | 2 | Register word address |
| regWr | input | 1 | Register write enable (write-one-to-clear) |
| regRd | input | 1 | Register read request |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, valid one cycle after regRd |

## Verification
Two functions can fall in the same cycle. A frame-stored strobe can coincide with a software clear of the same mailbox's flag, and it can also coincide with a read of the half that holds that mailbox. The bench issues the strobe and the clearing write on one clock edge, once for a mailbox whose pending flag is set and once for a mailbox whose pending flag is clear. It then reads back and expects the store to have won. It also reads a half on the very cycle a frame lands in it, and expects the pre-update value. A randomized phase then mixes strobes, writes and reads freely. A behavioural model checks every cycle, so collisions of all kinds are compared beat by beat.

// File: rtl/mbox_stat_pkg.sv
package mbox_stat_pkg;
  localparam int BOX_COUNT = 32;
  localparam int HALF_W    = 16;
  localparam int NUM_HALF  = BOX_COUNT / HALF_W;
  localparam int IDX_W     = $clog2(BOX_COUNT);
  localparam int NUM_REG   = 2 * NUM_HALF;
  localparam int ADDR_W    = $clog2(NUM_REG);
  localparam int PEND_BASE = 0;
  localparam int OVW_BASE  = NUM_HALF;

  typedef struct packed {
    logic [BOX_COUNT-1:0] setPend;
    logic [BOX_COUNT-1:0] setOvw;
    logic [BOX_COUNT-1:0] clrPend;
    logic [BOX_COUNT-1:0] clrOvw;
  } statStrobe_t;
endpackage

// File: rtl/mbox_stat_ctrl.sv
module mbox_stat_ctrl
  import mbox_stat_pkg::*;
(
  input  logic [BOX_COUNT-1:0] boxDir,
  input  logic                 storeValid,
  input  logic [IDX_W-1:0]     storeIdx,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWr,
  input  logic [HALF_W-1:0]    regWdata,
  input  logic [BOX_COUNT-1:0] pendQ,
  output statStrobe_t          strb
);
  logic [BOX_COUNT-1:0] reqMask;
  logic [BOX_COUNT-1:0] rxMask;
  logic [BOX_COUNT-1:0] clrPendV;
  logic [BOX_COUNT-1:0] clrOvwV;

  // one-hot of the addressed mailbox, masked to receive boxes
  always_comb begin
    reqMask = storeValid ? (BOX_COUNT'(1) << storeIdx) : '0;
    rxMask  = reqMask & ~boxDir;
  end

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    assign clrPendV[h*HALF_W +: HALF_W] =
      (regWr && regAddr == ADDR_W'(PEND_BASE + h)) ? regWdata : '0;
    assign clrOvwV[h*HALF_W +: HALF_W] =
      (regWr && regAddr == ADDR_W'(OVW_BASE + h)) ? regWdata : '0;
  end

  // overwrite judged on the pending state before this cycle's update
  always_comb begin
    strb.setPend = rxMask;
    strb.setOvw  = rxMask & pendQ;
    strb.clrPend = clrPendV;
    strb.clrOvw  = clrOvwV;
  end
endmodule

// File: rtl/mbox_stat_regs.sv
module mbox_stat_regs
  import mbox_stat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  statStrobe_t          strb,
  input  logic                 regRd,
  input  logic [ADDR_W-1:0]    regAddr,
  output logic [BOX_COUNT-1:0] pendQ,
  output logic [BOX_COUNT-1:0] ovwQ,
  output logic [HALF_W-1:0]    regRdata
);
  logic [HALF_W-1:0] view [NUM_REG];

  // set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      ovwQ  <= '0;
    end else begin
      pendQ <= (pendQ & ~strb.clrPend) | strb.setPend;
      ovwQ  <= (ovwQ  & ~strb.clrOvw)  | strb.setOvw;
    end
  end

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_view
    assign view[PEND_BASE + h] = pendQ[h*HALF_W +: HALF_W];
    assign view[OVW_BASE + h]  = ovwQ[h*HALF_W +: HALF_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdata <= '0;
    end else if (regRd && int'(regAddr) < NUM_REG) begin
      regRdata <= view[regAddr];
    end else begin
      regRdata <= '0;
    end
  end
endmodule

// File: rtl/mbox_rx_status.sv
module mbox_rx_status
  import mbox_stat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BOX_COUNT-1:0] boxDir,
  input  logic                 storeValid,
  input  logic [IDX_W-1:0]     storeIdx,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [HALF_W-1:0]    regWdata,
  output logic [HALF_W-1:0]    regRdata
);
  statStrobe_t          strb;
  logic [BOX_COUNT-1:0] pendQ;
  logic [BOX_COUNT-1:0] ovwQ;

  mbox_stat_ctrl i_ctrl (
    .boxDir    (boxDir),
    .storeValid(storeValid),
    .storeIdx  (storeIdx),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regWdata  (regWdata),
    .pendQ     (pendQ),
    .strb      (strb)
  );

  mbox_stat_regs i_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regRd   (regRd),
    .regAddr (regAddr),
    .pendQ   (pendQ),
    .ovwQ    (ovwQ),
    .regRdata(regRdata)
  );
endmodule

// File: rtl/mbox_rx_status_chk.sv
module mbox_rx_status_chk
  import mbox_stat_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [BOX_COUNT-1:0] boxDir,
  input logic                 storeValid,
  input logic [IDX_W-1:0]     storeIdx,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 regWr,
  input logic                 regRd,
  input logic [BOX_COUNT-1:0] pendQ,
  input logic [BOX_COUNT-1:0] ovwQ,
  input logic [HALF_W-1:0]    regRdata
);
  p_reset_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pendQ == '0 && ovwQ == '0 && regRdata == '0));

  // R4 and R7: a repeat store marks the overwrite even against a clear
  p_ovw_on_repeat_r4: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && !boxDir[storeIdx] && pendQ[storeIdx]) |=> ovwQ[$past(storeIdx)]);

  // R5: an overwrite bit only rises from a store into a receive box
  p_ovw_rise_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((ovwQ & ~$past(ovwQ)) != '0) |-> $past(storeValid && !boxDir[storeIdx]));

  p_first_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && !boxDir[storeIdx] && !pendQ[storeIdx] && !ovwQ[storeIdx])
      |=> (pendQ[$past(storeIdx)] && !ovwQ[$past(storeIdx)]));

  p_ovw_fall_wr_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((~ovwQ & $past(ovwQ)) != '0) |-> $past(regWr && int'(regAddr) >= OVW_BASE));

  p_pend_fall_wr_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((~pendQ & $past(pendQ)) != '0) |-> $past(regWr && int'(regAddr) < OVW_BASE));

  p_idle_rdata_r8: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |=> (regRdata == '0));
endmodule

bind mbox_rx_status mbox_rx_status_chk i_chk (.*);

// File: tb/test_mbox_rx_status.sv
module test_mbox_rx_status;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] boxDir = 32'h00F0_00F0;
  logic        storeValid = 1'b0;
  logic [4:0]  storeIdx = '0;
  logic [1:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 0;

  logic [31:0] mPend = '0;
  logic [31:0] mOvw = '0;
  logic [15:0] expRd = '0;

  mbox_rx_status i_mbox_rx_status (.*);

  always #5 clk = ~clk;

  // behavioural reference model
  always @(posedge clk) begin
    logic [31:0] nPend;
    logic [31:0] nOvw;
    if (!rstN) begin
      mPend = '0; mOvw = '0; expRd = '0;
    end else begin
      if (!regRd) expRd = '0;
      else case (regAddr)
        2'd0: expRd = mPend[15:0];
        2'd1: expRd = mPend[31:16];
        2'd2: expRd = mOvw[15:0];
        default: expRd = mOvw[31:16];
      endcase
      nPend = mPend; nOvw = mOvw;
      if (regWr) begin
        for (int b = 0; b < 16; b++) begin
          if (regWdata[b]) begin
            if (regAddr == 0) nPend[b] = 0;
            if (regAddr == 1) nPend[b+16] = 0;
            if (regAddr == 2) nOvw[b] = 0;
            if (regAddr == 3) nOvw[b+16] = 0;
          end
        end
      end
      if (storeValid && !boxDir[storeIdx]) begin
        if (mPend[storeIdx]) nOvw[storeIdx] = 1;
        nPend[storeIdx] = 1;
      end
      mPend = nPend; mOvw = nOvw;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      nChecks++;
      if (regRdata !== expRd) begin
        nBad++;
        $display("FAIL R8/R1 model compare: rdata=%h expected=%h at %0t", regRdata, expRd, $time);
      end
    end
  end

  task automatic cyc(input bit sv, input int idx, input bit wr, input bit rd,
                     input int addr, input logic [15:0] wd);
    storeValid = sv; storeIdx = 5'(idx); regWr = wr; regRd = rd;
    regAddr = 2'(addr); regWdata = wd;
    @(negedge clk);
    storeValid = 0; regWr = 0; regRd = 0; regWdata = '0;
  endtask

  task automatic store(input int idx);
    cyc(1, idx, 0, 0, 0, '0);
  endtask

  task automatic wrReg(input int addr, input logic [15:0] d);
    cyc(0, 0, 1, 0, addr, d);
  endtask

  task automatic rdReg(input int addr, input logic [15:0] exp, input string tag);
    cyc(0, 0, 0, 1, addr, '0);
    nChecks++;
    if (regRdata !== exp) begin
      nBad++;
      $display("FAIL %s: addr=%0d rdata=%h expected=%h", tag, addr, regRdata, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nChecks++; nBad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    nChecks++;
    if (regRdata !== 16'h0) begin
      nBad++; $display("FAIL R2 rdata in reset: actual=%h expected=0000", regRdata);
    end
    rstN = 1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) rdReg(a, 16'h0000, "R2 reset state");

    store(3);
    rdReg(0, 16'h0008, "R6 first store pending");
    rdReg(2, 16'h0000, "R6 first store no overwrite");
    store(3);
    rdReg(2, 16'h0008, "R4 repeat store overwrite");
    store(19); store(19);
    rdReg(1, 16'h0008, "R1 upper pending half");
    rdReg(3, 16'h0008, "R1 upper overwrite half");

    store(5); store(5); store(21);
    rdReg(0, 16'h0008, "R5 transmit box pending");
    rdReg(2, 16'h0008, "R5 transmit box overwrite");
    rdReg(1, 16'h0008, "R5 transmit box upper");

    wrReg(2, 16'h0000);
    rdReg(2, 16'h0008, "R3 write zero keeps");
    wrReg(2, 16'hFFFF);
    rdReg(2, 16'h0000, "R3 write one clears");
    wrReg(0, 16'h0008);
    rdReg(0, 16'h0000, "R3 pending clear");

    cyc(1, 19, 1, 0, 3, 16'h0008);
    rdReg(3, 16'h0008, "R7 overwrite set beats clear");
    cyc(1, 3, 1, 0, 0, 16'h0008);
    rdReg(0, 16'h0008, "R7 pending set beats clear");
    rdReg(2, 16'h0000, "R7 no overwrite from empty box");

    cyc(1, 0, 0, 1, 0, '0);
    nChecks++;
    if (regRdata !== 16'h0008) begin
      nBad++; $display("FAIL R8 same-cycle read: actual=%h expected=0008", regRdata);
    end
    rdReg(0, 16'h0009, "R8 read after update");

    wrReg(3, 16'hFFFF); wrReg(3, 16'hFFFF);
    rdReg(3, 16'h0000, "R3 write never sets");

    for (int i = 0; i < 400; i++) begin
      if (i % 100 == 0) boxDir = $urandom;
      cyc($urandom_range(0, 1) == 1, $urandom_range(0, 31), $urandom_range(0, 3) == 0,
          $urandom_range(0, 1) == 1, $urandom_range(0, 3), 16'($urandom));
    end
    repeat (2) @(negedge clk);
    finish();
  end
endmodule